// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers up to eight level-sensitive interrupt request lines and raises one interrupt output to a processor. It holds three registers: the levels now requesting service, the levels masked off, and the levels now being serviced. A fixed-priority resolver compares them. Line 0 has the highest priority and line 7 the lowest. The interrupt output is raised only when an unmasked request outranks every level already in service.

The processor answers with three acknowledge strobes. The first strobe returns a call opcode and moves the winning level into service. The second strobe returns the low byte of that level's service routine address and the third returns the high byte. Each address is a programmed 16-bit base plus four times the level number.

Setup takes two ordered writes: the base low byte, then the base high byte. After that, mask writes and end-of-interrupt commands may be issued at any time. Requests, acknowledges and writes are synchronous to the block clock.

Top module: `prio_intc`

## Requirements
- R1: After reset, `int_o` is 0, `dout` is 8'h00, all eight lines are masked and the block is not yet set up.
- R2: Until a write to address 0 (base low byte) is followed by a write to address 1 (base high byte), `int_o` stays 0 whatever the request lines do.
- R3: Once set up, each write to address 1 loads the mask, where bit i set blocks line i. A masked higher line does not stop a lower unmasked line from raising `int_o`.
- R4: An unmasked request first seen at a clock edge raises `int_o` at the following edge, provided its level number is lower than every level in service.
- R5: `int_o` stays high until the first acknowledge strobe, even if the request drops in the meantime. That strobe clears it, and it stays low until the third strobe has completed.
- R6: One clock after each acknowledge strobe, `dout` shows the response byte and then holds it. The bytes are 8'hCD, then bits 7:0, then bits 15:8 of base + 4 × level.
- R7: At the first strobe, the winning level is the lowest-numbered unmasked request that outranks every in-service level, and it is marked in service. If no such request exists, no level is marked and the address for level 7 is returned.
- R8: Writing 8'h20 to address 2 clears the lowest-numbered in-service level. Any other value written to address 2 has no effect.
- R9: Priority is fixed. While a level is in service, a request on a higher-numbered or equal level does not raise `int_o`, but a lower-numbered level does.
- R10: A write to address 0 restarts setup. It clears all in-service levels, drops `int_o`, abandons any acknowledge sequence in progress and masks every line.
- R11: The base-plus-offset sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir | input | 8 | Level-sensitive request lines, bit 0 highest priority |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 base low / restart, 1 base high or mask, 2 command |
| wr_data | input | 8 | Write data |
| inta | input | 1 | One-cycle acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| dout | output | 8 | Acknowledge response byte |

## Verification
A behavioural model of the request, mask and in-service sets predicts `int_o` and `dout` on every clock. Directed patterns then probe the distinctions that matter. A request on a level equal to or below the one in service must stay silent, while a higher one must nest. An end-of-interrupt with two levels in service must clear the higher-priority one, which shows up as the lower line being re-raised or not. A request dropped before acknowledge must leave no in-service bit behind, and a later level-7 request reveals this. A restart in the middle of an acknowledge must make the next strobe return the opcode again.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    CFG_IDLE    = 2'd0,
    CFG_WAIT_HI = 2'd1,
    CFG_READY   = 2'd2
  } cfg_state_e;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_LOW  = 2'd1,
    ACK_HIGH = 2'd2
  } ack_phase_e;

  localparam logic [1:0] ADDR_BASE_LO = 2'd0;
  localparam logic [1:0] ADDR_HI_MASK = 2'd1;
  localparam logic [1:0] ADDR_CMD     = 2'd2;

endpackage

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DW      = 8,
  parameter logic [7:0]  EOI_CMD = 8'h20,
  localparam int unsigned AW     = 2 * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic               ready,
  output logic [AW-1:0]      base,
  output logic [NUM_IRQ-1:0] mask,
  output logic               restart,
  output logic               eoi
);

  cfg_state_e         state_q, state_n;
  logic [AW-1:0]      base_q, base_n;
  logic [NUM_IRQ-1:0] mask_q, mask_n;

  always_comb begin
    state_n = state_q;
    base_n  = base_q;
    mask_n  = mask_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_BASE_LO: begin
          state_n          = CFG_WAIT_HI;
          base_n[DW-1:0]   = wr_data;
          mask_n           = '1;
        end
        ADDR_HI_MASK: begin
          if (state_q == CFG_WAIT_HI) begin
            base_n[AW-1:DW] = wr_data;
            state_n         = CFG_READY;
          end else if (state_q == CFG_READY) begin
            mask_n = wr_data[NUM_IRQ-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CFG_IDLE;
      base_q  <= '0;
      mask_q  <= '1;
    end else begin
      state_q <= state_n;
      base_q  <= base_n;
      mask_q  <= mask_n;
    end
  end

  assign ready   = (state_q == CFG_READY);
  assign base    = base_q;
  assign mask    = mask_q;
  assign restart = wr_en && (wr_addr == ADDR_BASE_LO);
  assign eoi     = ready && wr_en && (wr_addr == ADDR_CMD) && (wr_data == EOI_CMD[DW-1:0]);

endmodule

// File: rtl/intc_resolver.sv
module intc_resolver #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LW     = $clog2(NUM_IRQ)
) (
  input  logic               ready,
  input  logic [NUM_IRQ-1:0] irr,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] isr,
  output logic               grant_vld,
  output logic [LW-1:0]      grant_lvl,
  output logic [NUM_IRQ-1:0] grant_onehot,
  output logic [NUM_IRQ-1:0] eoi_onehot
);

  logic [NUM_IRQ-1:0] cand;
  logic [NUM_IRQ-1:0] cand_below;
  logic [NUM_IRQ-1:0] isr_below;

  assign cand = irr & ~mask;

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_chain
    if (gi == 0) begin : g_first
      assign cand_below[gi] = 1'b0;
      assign isr_below[gi]  = 1'b0;
    end else begin : g_rest
      assign cand_below[gi] = cand_below[gi-1] | cand[gi-1];
      assign isr_below[gi]  = isr_below[gi-1]  | isr[gi-1];
    end
    assign grant_onehot[gi] = ready & cand[gi] & ~cand_below[gi] & ~isr_below[gi] & ~isr[gi];
    assign eoi_onehot[gi]   = isr[gi] & ~isr_below[gi];
  end

  assign grant_vld = |grant_onehot;

  always_comb begin
    grant_lvl = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant_onehot[i]) grant_lvl = LW'(i);
    end
  end

endmodule

// File: rtl/intc_ack.sv
module intc_ack
  import intc_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned VEC_SHIFT = 2,
  parameter logic [7:0]  CALL_OP   = 8'hCD,
  localparam int unsigned AW       = 2 * DW,
  localparam int unsigned LW       = $clog2(NUM_IRQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          inta,
  input  logic          grant_vld,
  input  logic [LW-1:0] grant_lvl,
  input  logic [AW-1:0] base,
  output logic          ack_start,
  output logic          busy,
  output logic [DW-1:0] dout
);

  ack_phase_e    phase_q, phase_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic [DW-1:0] dout_q, dout_n;
  logic [AW-1:0] vec;

  assign vec       = base + (AW'(lvl_q) << VEC_SHIFT);
  assign ack_start = inta && (phase_q == ACK_IDLE) && !restart;
  assign busy      = (phase_q != ACK_IDLE);

  always_comb begin
    phase_n = phase_q;
    lvl_n   = lvl_q;
    dout_n  = dout_q;
    if (restart) begin
      phase_n = ACK_IDLE;
    end else if (inta) begin
      case (phase_q)
        ACK_IDLE: begin
          dout_n  = CALL_OP[DW-1:0];
          lvl_n   = grant_vld ? grant_lvl : LW'(NUM_IRQ - 1);
          phase_n = ACK_LOW;
        end
        ACK_LOW: begin
          dout_n  = vec[DW-1:0];
          phase_n = ACK_HIGH;
        end
        default: begin
          dout_n  = vec[AW-1:DW];
          phase_n = ACK_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ACK_IDLE;
      lvl_q   <= '0;
      dout_q  <= '0;
    end else begin
      phase_q <= phase_n;
      lvl_q   <= lvl_n;
      dout_q  <= dout_n;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned VEC_SHIFT = 2,
  parameter logic [7:0]  CALL_OP   = 8'hCD,
  parameter logic [7:0]  EOI_CMD   = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] ir,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               inta,
  output logic               int_o,
  output logic [DW-1:0]      dout
);

  localparam int unsigned AW = 2 * DW;
  localparam int unsigned LW = $clog2(NUM_IRQ);

  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic [NUM_IRQ-1:0] irr_q, irr_n;
  logic [NUM_IRQ-1:0] isr_q, isr_n;
  logic               int_q, int_n;

  logic               cfg_ready, cfg_restart, cfg_eoi;
  logic [AW-1:0]      cfg_base;
  logic [NUM_IRQ-1:0] cfg_mask;
  logic               grant_vld;
  logic [LW-1:0]      grant_lvl;
  logic [NUM_IRQ-1:0] grant_onehot, eoi_onehot;
  logic               ack_start, ack_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  intc_cfg #(.NUM_IRQ(NUM_IRQ), .DW(DW), .EOI_CMD(EOI_CMD)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ready   (cfg_ready),
    .base    (cfg_base),
    .mask    (cfg_mask),
    .restart (cfg_restart),
    .eoi     (cfg_eoi)
  );

  intc_resolver #(.NUM_IRQ(NUM_IRQ)) u_res (
    .ready        (cfg_ready),
    .irr          (irr_q),
    .mask         (cfg_mask),
    .isr          (isr_q),
    .grant_vld    (grant_vld),
    .grant_lvl    (grant_lvl),
    .grant_onehot (grant_onehot),
    .eoi_onehot   (eoi_onehot)
  );

  intc_ack #(
    .NUM_IRQ(NUM_IRQ), .DW(DW), .VEC_SHIFT(VEC_SHIFT), .CALL_OP(CALL_OP)
  ) u_ack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart   (cfg_restart),
    .inta      (inta),
    .grant_vld (grant_vld),
    .grant_lvl (grant_lvl),
    .base      (cfg_base),
    .ack_start (ack_start),
    .busy      (ack_busy),
    .dout      (dout)
  );

  always_comb begin
    irr_n = ir;
    isr_n = isr_q;
    if (cfg_restart) begin
      isr_n = '0;
    end else begin
      if (cfg_eoi)                isr_n = isr_n & ~eoi_onehot;
      if (ack_start && grant_vld) isr_n = isr_n | grant_onehot;
    end
  end

  always_comb begin
    if (cfg_restart)    int_n = 1'b0;
    else if (ack_start) int_n = 1'b0;
    else if (ack_busy)  int_n = 1'b0;
    else if (int_q)     int_n = 1'b1;
    else                int_n = grant_vld;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irr_q <= '0;
      isr_q <= '0;
      int_q <= 1'b0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      int_q <= int_n;
    end
  end

  assign int_o = int_q;

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DW      = 8,
  parameter logic [7:0]  CALL_OP = 8'hCD
) (
  input logic               clk,
  input logic               rst_n,
  input logic               int_o,
  input logic               inta,
  input logic [DW-1:0]      dout,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic [NUM_IRQ-1:0] irr,
  input logic [NUM_IRQ-1:0] mask,
  input logic [NUM_IRQ-1:0] isr,
  input logic               ready,
  input logic               busy
);

  a_r2_no_int_unready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_o);

  a_r3_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_o) |-> $past(|(irr & ~mask)));

  a_r5_int_held: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && !inta && !(wr_en && wr_addr == 2'd0)) |=> int_o);

  a_r5_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !int_o);

  a_r6_call_first: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !busy && !(wr_en && wr_addr == 2'd0)) |=> (dout == CALL_OP[DW-1:0]));

  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (!int_o && isr == '0 && !ready && !busy));

endmodule

bind prio_intc intc_chk #(.NUM_IRQ(NUM_IRQ), .DW(DW), .CALL_OP(CALL_OP)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .int_o   (int_o),
  .inta    (inta),
  .dout    (dout),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .irr     (irr_q),
  .mask    (cfg_mask),
  .isr     (isr_q),
  .ready   (cfg_ready),
  .busy    (ack_busy)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ir = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       inta = 1'b0;
  logic       int_o;
  logic [7:0] dout;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rst_n(rst_n), .ir(ir), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .inta(inta), .int_o(int_o), .dout(dout)
  );

  // Behavioural reference model
  bit   m_int, m_ready, m_waithi;
  bit   m_req[8], m_msk[8], m_svc[8];
  int   m_phase, m_lvl, m_base;
  logic [7:0] m_dout;

  function automatic int lowest_req();
    for (int i = 0; i < 8; i++) if (m_req[i] && !m_msk[i]) return i;
    return 8;
  endfunction

  function automatic int lowest_svc();
    for (int i = 0; i < 8; i++) if (m_svc[i]) return i;
    return 8;
  endfunction

  task automatic model_reset();
    m_int = 0; m_ready = 0; m_waithi = 0; m_phase = 0; m_lvl = 0; m_base = 0; m_dout = 0;
    for (int i = 0; i < 8; i++) begin m_req[i] = 0; m_msk[i] = 1; m_svc[i] = 0; end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int best, top_svc, vec;
      bit ok;
      best = lowest_req();
      top_svc = lowest_svc();
      ok = m_ready && best < 8 && best < top_svc;
      if (wr_en && wr_addr == 0) begin
        m_base = (m_base & 32'hFF00) | wr_data;
        m_ready = 0; m_waithi = 1; m_int = 0; m_phase = 0;
        for (int i = 0; i < 8; i++) begin m_msk[i] = 1; m_svc[i] = 0; end
      end else begin
        if (wr_en && wr_addr == 1) begin
          if (m_waithi) begin m_base = (m_base & 32'h00FF) | (int'(wr_data) << 8); m_waithi = 0; m_ready = 1; end
          else if (m_ready) for (int i = 0; i < 8; i++) m_msk[i] = wr_data[i];
        end
        if (wr_en && wr_addr == 2 && m_ready && wr_data == 8'h20 && top_svc < 8) m_svc[top_svc] = 0;
        if (m_phase != 0) m_int = 0;
        else if (inta) m_int = 0;
        else if (!m_int) m_int = ok;
        if (inta) begin
          vec = (m_base + m_lvl * 4) & 32'hFFFF;
          if (m_phase == 0) begin
            m_dout = 8'hCD; m_lvl = ok ? best : 7;
            if (ok) m_svc[best] = 1;
            m_phase = 1;
          end else if (m_phase == 1) begin m_dout = vec[7:0]; m_phase = 2; end
          else begin m_dout = vec[15:8]; m_phase = 0; end
        end
      end
      for (int i = 0; i < 8; i++) m_req[i] = ir[i];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int_o !== m_int) begin
        failures++;
        $display("FAIL R4 model int_o actual=%0b expected=%0b t=%0t", int_o, m_int, $time);
      end
      checks++;
      if (dout !== m_dout) begin
        failures++;
        $display("FAIL R6 model dout actual=%02h expected=%02h t=%0t", dout, m_dout, $time);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
  endtask

  task automatic ack3(string tag, logic [7:0] lo, logic [7:0] hi);
    pulse(); check({tag, " call"}, dout, 8'hCD); check("R5 int cleared", int_o, 0);
    pulse(); check({tag, " low"}, dout, lo);
    pulse(); check({tag, " high"}, dout, hi);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      summary();
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(4);
    check("R1 int after reset", int_o, 0);
    check("R1 dout after reset", dout, 0);
    ir = 8'hFF; wait_n(4);
    check("R2 no int before setup", int_o, 0);
    ir = 8'h00;

    wr(0, 8'h40); wr(1, 8'h12);
    ir = 8'h08; wait_n(4);
    check("R3 default mask blocks", int_o, 0);
    ir = 8'h00; wr(1, 8'h00); wait_n(2);
    @(negedge clk); ir = 8'h08;
    @(negedge clk); check("R4 not yet", int_o, 0);
    @(negedge clk); check("R4 raised", int_o, 1);
    ack3("R6 level3", 8'h4C, 8'h12);
    wait_n(3); check("R9 same level silent", int_o, 0);

    ir = 8'h28; wait_n(3); check("R9 lower silent", int_o, 0);
    ir = 8'h2A; wait_n(3); check("R9 higher nests", int_o, 1);
    ack3("R7 level1", 8'h44, 8'h12);

    wr(2, 8'h11); wait_n(3); check("R8 other cmd ignored", int_o, 0);
    wr(2, 8'h20); wait_n(2); check("R8 eoi clears level1", int_o, 1);
    ack3("R8 level1 again", 8'h44, 8'h12);
    ir = 8'h28;
    wr(2, 8'h20); wait_n(3); check("R8 level3 still in service", int_o, 0);
    wr(2, 8'h20); wait_n(2); check("R8 level3 released", int_o, 1);
    ack3("R6 level3 again", 8'h4C, 8'h12);
    wr(2, 8'h20);

    wr(1, 8'h08); wait_n(3); check("R3 masked higher skipped", int_o, 1);
    ack3("R3 level5", 8'h54, 8'h12);
    wr(2, 8'h20); ir = 8'h00; wr(1, 8'h00);

    ir = 8'h04; wait_n(3); check("R4 level2", int_o, 1);
    ir = 8'h00; wait_n(3); check("R5 held after drop", int_o, 1);
    ack3("R7 spurious", 8'h5C, 8'h12);
    ir = 8'h80; wait_n(3); check("R7 no stale in-service", int_o, 1);
    ack3("R7 level7", 8'h5C, 8'h12);
    wr(2, 8'h20);

    ir = 8'h01; wait_n(3); check("R10 pre", int_o, 1);
    wr(0, 8'h00); check("R10 int dropped", int_o, 0);
    wr(1, 8'h80); wait_n(3); check("R10 mask reset", int_o, 0);
    wr(1, 8'h00); wait_n(2); check("R10 ready again", int_o, 1);
    pulse(); check("R10 call", dout, 8'hCD);
    wr(0, 8'hF8); wr(1, 8'hFF); wr(1, 8'h00); wait_n(2);
    check("R10 after abort", int_o, 1);
    ack3("R10 fresh sequence", 8'hF8, 8'hFF);
    ir = 8'h80; wr(2, 8'h20); wait_n(2);
    ack3("R11 wrap", 8'h14, 8'h00);
    ir = 8'h00; wait_n(3);

    done = 1;
    summary();
  end

endmodule